// File: doc/BRIEF.md
# Interrupt Flag and Enable Register Pair

This block keeps the pending-interrupt state of a peripheral and the mask that decides which pending events may reach the processor. It has seven flag bits. Each flag is raised by a one-cycle event pulse from a neighbouring source:

| Flag bit | Source |
|---|---|
| 0 | secondary control line of port A |
| 1 | primary control line of port A |
| 2 | spare source |
| 3 | secondary control line of port B |
| 4 | primary control line of port B |
| 5 | second timer |
| 6 | first timer |

A flag is lowered either by a clear pulse from the same source logic or by software. The block drives a single active-low interrupt request. That request is low whenever at least one flag is both pending and enabled.

Software reaches the two registers over a byte-wide bus with a 4-bit register select, a select strobe and a write strobe.

- **Flag register (select 13).** Writes are write-one-to-clear. On a read, bit 7 summarises whether any enabled flag is pending.
- **Enable register (select 14).** On a write, bit 7 of the byte chooses whether the ones in bits 6:0 set or clear enables. On a read, bit 7 is always one.

The reset input is asynchronous and active low. Its release is synchronised inside the block, so the registers leave reset two clock edges after the input goes high.

Top module: `irq_flag_enable`

## Requirements
- R1: While reset is held and after it is released, all flags and all enables are zero and `irq_n` is high. After release, a read of select 13 returns 0x00 and a read of select 14 returns 0x80.
- R2: A one on `set_evt[i]` at a clock edge makes flag i one from that edge on.
- R3: A one on `clr_evt[i]`, with no set on the same bit, makes flag i zero at that edge.
- R4: When a set pulse and any clear (a `clr_evt` pulse or a software write-one) hit the same flag in the same cycle, the flag ends up set.
- R5: A write to select 13 clears every flag whose bit in `wdata[6:0]` is one. Flags written with zero, and `wdata[7]`, have no effect.
- R6: A write to select 14 with `wdata[7]` = 1 sets each enable whose bit in `wdata[6:0]` is one and leaves the others unchanged.
- R7: A write to select 14 with `wdata[7]` = 0 clears each enable whose bit in `wdata[6:0]` is one and leaves the others unchanged.
- R8: With `cs` high and select 13, `rdata[6:0]` shows the flags. `rdata[7]` is the OR over all bits of flag AND enable.
- R9: With `cs` high and select 14, `rdata[6:0]` shows the enables and `rdata[7]` reads 1.
- R10: `irq_n` is driven 0 when any flag is set together with its enable, and is driven 1 otherwise.
- R11: A write takes effect only when both `cs` and `we` are high and the select is 13 or 14. For any other select, or with `cs` low, `rdata` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cs | input | 1 | Register access select |
| we | input | 1 | Write strobe, qualified by cs |
| reg_sel | input | 4 | Register select (13 flags, 14 enables) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the selected register |
| set_evt | input | 7 | One-cycle set pulses, one per flag |
| clr_evt | input | 7 | One-cycle clear pulses, one per flag |
| irq_n | output | 1 | Active-low interrupt request, driven both ways |

## Verification
The bench sweeps every combination of the seven enable bits against every combination of the seven flag bits. For each combination it checks both readbacks and the request line. A design that ORed the summary bit over raw flags instead of enabled flags would raise it with the mask at zero. A design that ignored the polarity bit of the enable write would fail the sweep at once.

Directed cycles collide a set pulse with a hardware clear, and with a software write-one, on the same bit. A design in which clear had priority would lose the event.

A long pseudo-random phase mixes foreign selects, writes with `cs` low, and writes with bit 7 set to the flag register. A design that decoded too few select bits, or that let bit 7 clear anything, would corrupt state that a later read exposes.

// File: rtl/irqfe_pkg.sv
package irqfe_pkg;
  localparam int unsigned IRQFE_SRC_N     = 7;
  localparam int unsigned IRQFE_SEL_W     = 4;
  localparam int unsigned IRQFE_FLAG_ADDR = 13;
  localparam int unsigned IRQFE_EN_ADDR   = 14;
endpackage

// File: rtl/irqfe_rst_sync.sv
module irqfe_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n_async) begin
        if (!rst_n_async) sync_q <= '0;
        else              sync_q <= 1'b1;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n_async) begin
        if (!rst_n_async) sync_q <= '0;
        else              sync_q <= {sync_q[STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/irqfe_decode.sv
module irqfe_decode #(
  parameter int unsigned SEL_W     = 4,
  parameter int unsigned FLAG_ADDR = 13,
  parameter int unsigned EN_ADDR   = 14
) (
  input  logic             cs,
  input  logic             we,
  input  logic [SEL_W-1:0] reg_sel,
  output logic             flag_hit,
  output logic             en_hit,
  output logic             flag_wr,
  output logic             en_wr
);
  localparam logic [SEL_W-1:0] FLAG_SEL = SEL_W'(FLAG_ADDR);
  localparam logic [SEL_W-1:0] EN_SEL   = SEL_W'(EN_ADDR);

  always_comb begin
    flag_hit = cs && (reg_sel == FLAG_SEL);
    en_hit   = cs && (reg_sel == EN_SEL);
    flag_wr  = flag_hit && we;
    en_wr    = en_hit && we;
  end
endmodule

// File: rtl/irqfe_flag_reg.sv
module irqfe_flag_reg #(
  parameter int unsigned SRC_N = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_N-1:0] set_pulse,
  input  logic [SRC_N-1:0] hw_clr,
  input  logic             sw_wr,
  input  logic [SRC_N-1:0] sw_mask,
  output logic [SRC_N-1:0] flags_q
);
  logic [SRC_N-1:0] clr_all;
  logic [SRC_N-1:0] flags_d;
  logic             flags_ce;

  always_comb begin
    clr_all  = hw_clr | (sw_wr ? sw_mask : '0);
    flags_d  = (flags_q & ~clr_all) | set_pulse;
    flags_ce = (|set_pulse) || (|clr_all);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flags_q <= '0;
    else if (flags_ce) flags_q <= flags_d;
  end

  genvar gi;
  generate
    for (gi = 0; gi < SRC_N; gi++) begin : g_chk
      // R2 R4
      flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_pulse[gi] |=> flags_q[gi]);
      // R3 R5
      flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((hw_clr[gi] || (sw_wr && sw_mask[gi])) && !set_pulse[gi]) |=> !flags_q[gi]);
    end
  endgenerate

  // R5 R11
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_pulse == '0 && hw_clr == '0 && !sw_wr) |=> $stable(flags_q));
endmodule

// File: rtl/irqfe_enable_reg.sv
module irqfe_enable_reg #(
  parameter int unsigned SRC_N = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic             polarity,
  input  logic [SRC_N-1:0] wmask,
  output logic [SRC_N-1:0] en_q
);
  logic [SRC_N-1:0] en_d;

  always_comb begin
    if (polarity) en_d = en_q | wmask;
    else          en_d = en_q & ~wmask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  en_q <= '0;
    else if (wr) en_q <= en_d;
  end

  // R6
  en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && polarity) |=> ((en_q & $past(wmask)) == $past(wmask)));
  // R7
  en_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !polarity) |=> ((en_q & $past(wmask)) == '0));
  // R11
  en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(en_q));
endmodule

// File: rtl/irq_flag_enable.sv
module irq_flag_enable
  import irqfe_pkg::*;
#(
  parameter int unsigned SRC_N     = IRQFE_SRC_N,
  parameter int unsigned SEL_W     = IRQFE_SEL_W,
  parameter int unsigned FLAG_ADDR = IRQFE_FLAG_ADDR,
  parameter int unsigned EN_ADDR   = IRQFE_EN_ADDR
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs,
  input  logic             we,
  input  logic [SEL_W-1:0] reg_sel,
  input  logic [SRC_N:0]   wdata,
  output logic [SRC_N:0]   rdata,
  input  logic [SRC_N-1:0] set_evt,
  input  logic [SRC_N-1:0] clr_evt,
  output logic             irq_n
);
  localparam int unsigned DATA_W = SRC_N + 1;

  logic             rst_sync_n;
  logic             flag_hit, en_hit, flag_wr, en_wr;
  logic [SRC_N-1:0] flags_q, en_q, active;

  irqfe_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n_async(rst_n), .rst_n_sync(rst_sync_n)
  );

  irqfe_decode #(.SEL_W(SEL_W), .FLAG_ADDR(FLAG_ADDR), .EN_ADDR(EN_ADDR)) u_dec (
    .cs(cs), .we(we), .reg_sel(reg_sel),
    .flag_hit(flag_hit), .en_hit(en_hit), .flag_wr(flag_wr), .en_wr(en_wr)
  );

  irqfe_flag_reg #(.SRC_N(SRC_N)) u_flags (
    .clk(clk), .rst_n(rst_sync_n), .set_pulse(set_evt), .hw_clr(clr_evt),
    .sw_wr(flag_wr), .sw_mask(wdata[SRC_N-1:0]), .flags_q(flags_q)
  );

  irqfe_enable_reg #(.SRC_N(SRC_N)) u_en (
    .clk(clk), .rst_n(rst_sync_n), .wr(en_wr), .polarity(wdata[SRC_N]),
    .wmask(wdata[SRC_N-1:0]), .en_q(en_q)
  );

  always_comb begin
    active = flags_q & en_q;
    irq_n  = ~(|active);
    if (flag_hit)    rdata = {|active, flags_q};
    else if (en_hit) rdata = {1'b1, en_q};
    else             rdata = '0;
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_sync_n |-> irq_n);
  // R8 R10
  summary_match_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    flag_hit |-> (rdata[DATA_W-1] == !irq_n));
  // R9
  en_top_bit_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    en_hit |-> rdata[DATA_W-1]);
  // R11
  idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !cs |-> (rdata == '0));
endmodule

// File: tb/irq_flag_enable_tb_top.sv
module irq_flag_enable_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cs, we;
  logic [3:0] sel;
  logic [7:0] wd;
  logic [7:0] rdata;
  logic [6:0] set_evt, clr_evt;
  logic       irq_n;

  int unsigned n_vec = 0;
  int unsigned n_bad = 0;
  logic [6:0]  m_flags, m_en;
  logic [31:0] rng = 32'h1234_5678;

  always #10 clk = ~clk;

  irq_flag_enable dut_i (
    .clk(clk), .rst_n(rst_n), .cs(cs), .we(we), .reg_sel(sel), .wdata(wd),
    .rdata(rdata), .set_evt(set_evt), .clr_evt(clr_evt), .irq_n(irq_n)
  );

  function automatic logic [31:0] xs(input logic [31:0] s);
    logic [31:0] t;
    t = s;
    t = t ^ (t << 13);
    t = t ^ (t >> 17);
    t = t ^ (t << 5);
    return t;
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  task automatic step(input logic c, input logic w, input logic [3:0] s, input logic [7:0] d,
                      input logic [6:0] st, input logic [6:0] cl, input string tag);
    logic [6:0] swc;
    logic [7:0] exp;
    cs = c; we = w; sel = s; wd = d; set_evt = st; clr_evt = cl;
    @(posedge clk);
    swc = (c && w && s == 4'd13) ? d[6:0] : 7'h00;
    m_flags = (m_flags & ~(cl | swc)) | st;
    if (c && w && s == 4'd14) m_en = d[7] ? (m_en | d[6:0]) : (m_en & ~d[6:0]);
    @(negedge clk);
    if (c && s == 4'd13)      exp = {|(m_flags & m_en), m_flags};
    else if (c && s == 4'd14) exp = {1'b1, m_en};
    else                      exp = 8'h00;
    check(tag, rdata, exp);
    check("R10", {7'h00, irq_n}, {7'h00, ~|(m_flags & m_en)});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_vec++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    report();
    $finish;
  end

  initial begin
    rst_n = 1'b0; cs = 1'b0; we = 1'b0; sel = 4'd0; wd = 8'h00;
    set_evt = 7'h00; clr_evt = 7'h00;
    m_flags = 7'h00; m_en = 7'h00;
    repeat (3) @(negedge clk);
    // R1: request idle during reset
    check("R1", {7'h00, irq_n}, 8'h01);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    step(1, 0, 4'd13, 8'h00, 7'h00, 7'h00, "R1");
    step(1, 0, 4'd14, 8'h00, 7'h00, 7'h00, "R1");
    // R2: events raise flags
    step(1, 0, 4'd13, 8'h00, 7'h05, 7'h00, "R2");
    // R6: set enable bit 0
    step(1, 1, 4'd14, 8'h81, 7'h00, 7'h00, "R6");
    // R8: summary bit follows enabled flag
    step(1, 0, 4'd13, 8'h00, 7'h00, 7'h00, "R8");
    // R3: hardware clear
    step(1, 0, 4'd13, 8'h00, 7'h00, 7'h01, "R3");
    // R4: set beats hardware clear, then set beats software clear
    step(1, 0, 4'd13, 8'h00, 7'h02, 7'h02, "R4");
    step(1, 1, 4'd13, 8'h02, 7'h02, 7'h00, "R4");
    // R5: write-one-to-clear, bit 7 ignored
    step(1, 1, 4'd13, 8'h84, 7'h00, 7'h00, "R5");
    step(1, 0, 4'd13, 8'h00, 7'h00, 7'h00, "R5");
    // R7: clear enables
    step(1, 1, 4'd14, 8'h7E, 7'h00, 7'h00, "R7");
    step(1, 1, 4'd14, 8'h01, 7'h00, 7'h00, "R7");
    // R9: enable readback
    step(1, 1, 4'd14, 8'hC2, 7'h00, 7'h00, "R9");
    // R11: no effect without cs or with foreign select
    step(0, 1, 4'd13, 8'h7F, 7'h00, 7'h00, "R11");
    step(0, 1, 4'd14, 8'h7F, 7'h00, 7'h00, "R11");
    step(1, 1, 4'd3,  8'hFF, 7'h00, 7'h00, "R11");
    step(1, 0, 4'd13, 8'h00, 7'h00, 7'h00, "R11");
    step(1, 0, 4'd14, 8'h00, 7'h00, 7'h00, "R11");
    // R8 R9: full sweep of enable patterns against flag patterns
    for (int e = 0; e < 128; e++) begin
      for (int f = 0; f < 128; f++) begin
        step(1, 1, 4'd14, 8'h7F, 7'(f), 7'h00, "R2");
        step(1, 1, 4'd14, {1'b1, 7'(e)}, 7'h00, 7'h00, "R6");
        step(1, 0, 4'd13, 8'h00, 7'h00, 7'h00, "R8");
        step(1, 1, 4'd13, 8'h7F, 7'h00, 7'h00, "R5");
      end
    end
    // R11: pseudo-random mix of selects, strobes and events
    for (int k = 0; k < 5000; k++) begin
      logic [31:0] a;
      logic [31:0] b;
      logic [3:0]  s;
      rng = xs(rng); a = rng;
      rng = xs(rng); b = rng;
      s = a[3] ? (a[4] ? 4'd13 : 4'd14) : a[8:5];
      step(a[0] | a[1], a[2], s, a[16:9], a[23:17] & a[30:24], b[6:0] & b[13:7], "R11");
    end
    report();
    $finish;
  end
endmodule